// File: doc/BRIEF.md
# SDRAM Power-Down Sequencer

This block sits on the controller side of a low-power SDRAM. When the rest of the controller reports that it has nothing to do, the block takes the memory into power-down. It pulls the clock-enable line low and takes control of the command bus. When a wake request or a fresh access arrives, it brings the memory back out. It also brings the memory out on its own before the refresh interval of one row runs out, so that the refresh engine can issue its command in time.

While the memory is down, the block reports what kind of power-down it is in. The kind is fixed by the bank state sampled when entry was decided. If every bank was closed, the memory is in precharge power-down. If at least one row was open, it is in active power-down. Entry and exit each cost one cycle before the state counts as reached. The cycle in which clock-enable returns high always carries a NOP.

Time limits are given in nanoseconds and converted to clock cycles by rounding up. The row refresh interval (15.625 µs) and the clock period (7.5 ns by default) are parameters, and the forced-exit margin is a parameter in cycles.

Top module: `pdn_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, cke is 1, pd_mode is 0, ready is 1, cmd_own is 0 and refresh_due is 0.
- R2: When ready is 1 and idle_req is 1 at a clock edge, with access_busy, wake_req and new_access all 0, cke is 0 from that edge on. pd_mode stays 0 and cmd is NOP (4'b0111) during that first entry cycle.
- R3: No entry starts while access_busy, wake_req or new_access is 1. In that case cke stays 1 and ready stays 1.
- R4: pd_mode is 1 (precharge power-down) when bank_open was all zero at the entry edge and 2 (active power-down) when any bit was set. It becomes valid one cycle after cke falls, holds through the exit cycle, and is 0 at all other times. The value 3 never appears.
- R5: cke stays 0 for every cycle the memory is down. Changes on bank_open while down do not alter pd_mode.
- R6: A wake_req or new_access seen at an edge while down raises cke at that edge, with cmd NOP (4'b0111) and ready still 0. On the following edge ready returns to 1 and pd_mode to 0.
- R7: While down (pd_mode nonzero and cke 0), cmd is DESELECT (4'b1111, chip-select high). cmd_own is 1 from the entry cycle through the exit cycle.
- R8: The refresh budget is REF_CYC = ceil(REF_ROW_NS*1000/CLK_PS) cycles. If no wake arrives, cke stays low for exactly REF_CYC-MARGIN+1 cycles and then rises with refresh_due at 1 for that single exit cycle.
- R9: ready is 0 from the entry cycle through the exit cycle and 1 otherwise.
- R10: Dropping idle_req while down has no effect. cke stays 0 until a wake, a new access or the budget ends it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Controller has nothing to issue; power-down wanted |
| access_busy | input | 1 | An access is still in flight |
| wake_req | input | 1 | External request to leave power-down |
| new_access | input | 1 | A new access is waiting |
| bank_open | input | NBANK | One bit per bank, set when a row is open |
| cke | output | 1 | Clock-enable line to the memory |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} while cmd_own is 1 |
| cmd_own | output | 1 | Block owns the command bus |
| ready | output | 1 | Memory available for normal commands |
| pd_mode | output | 2 | 0 none, 1 precharge power-down, 2 active power-down |
| refresh_due | output | 1 | Exit was forced by the refresh budget |

## Verification
The bench goes after the exact length of a budget-forced stay. A counter loaded or compared one cycle off would shift the rise of cke and move refresh_due by a cycle. It checks that the power-down kind is latched at the entry edge: a design that samples bank_open later, or keeps following it, would report the wrong mode after banks change while down. Entry under a busy flag or a pending access is tried; a missing guard would drop cke with work outstanding. The exit cycle is checked for NOP with ready still low; dropping the one-cycle exit latency would reopen the bus too early.

// File: rtl/pdn_pkg.sv
`timescale 1ns/1ps
package pdn_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_ENTER = 2'd1,
        ST_DOWN  = 2'd2,
        ST_EXIT  = 2'd3
    } pdn_state_e;

    typedef enum logic [1:0] {
        PD_NONE = 2'd0,
        PD_PRE  = 2'd1,
        PD_ACT  = 2'd2
    } pdn_mode_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_DESEL = 4'b1111;

    typedef struct packed {
        logic       cke;
        logic [3:0] cmd;
        logic       own;
        logic       ready;
    } pdn_pins_t;

    // nanoseconds to whole cycles, rounded up
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/pdn_budget.sv
`timescale 1ns/1ps
module pdn_budget #(
    parameter int unsigned REF_CYC = 2084,
    parameter int unsigned MARGIN  = 16,
    parameter int unsigned CNT_W   = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic run,
    output logic hit
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CNT_W'(REF_CYC);
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign hit = (cnt_q == CNT_W'(MARGIN));
endmodule

// File: rtl/pdn_fsm.sv
`timescale 1ns/1ps
module pdn_fsm
    import pdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idle_req,
    input  logic       access_busy,
    input  logic       wake_req,
    input  logic       new_access,
    input  logic       any_open,
    input  logic       budget_hit,
    output pdn_state_e state,
    output pdn_mode_e  mode,
    output logic       due,
    output logic       load,
    output logic       run
);
    pdn_state_e state_q, state_d;
    pdn_mode_e  cls_q, mode_q;
    logic       due_q;
    logic       go_down, leave;

    assign go_down = idle_req && !access_busy && !wake_req && !new_access;
    assign leave   = budget_hit || wake_req || new_access;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (go_down) state_d = ST_ENTER;
            ST_ENTER: state_d = ST_DOWN;
            ST_DOWN:  if (leave) state_d = ST_EXIT;
            ST_EXIT:  state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            cls_q   <= PD_NONE;
            mode_q  <= PD_NONE;
            due_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN && go_down)
                cls_q <= any_open ? PD_ACT : PD_PRE;
            if (state_q == ST_ENTER)
                mode_q <= cls_q;
            if (state_q == ST_DOWN && budget_hit)
                due_q <= 1'b1;
            if (state_q == ST_EXIT) begin
                mode_q <= PD_NONE;
                due_q  <= 1'b0;
            end
        end
    end

    assign load  = (state_q == ST_RUN) && go_down;
    assign run   = (state_q == ST_ENTER) || (state_q == ST_DOWN);
    assign state = state_q;
    assign mode  = mode_q;
    assign due   = due_q;
endmodule

// File: rtl/pdn_pins.sv
`timescale 1ns/1ps
module pdn_pins
    import pdn_pkg::*;
#(
    parameter bit DOWN_DESEL = 1'b1
) (
    input  pdn_state_e state,
    output pdn_pins_t  pins
);
    logic [3:0] down_cmd;

    generate
        if (DOWN_DESEL) begin : g_desel
            assign down_cmd = CMD_DESEL;
        end else begin : g_nop
            assign down_cmd = CMD_NOP;
        end
    endgenerate

    always_comb begin
        pins.cke   = 1'b1;
        pins.cmd   = CMD_NOP;
        pins.own   = 1'b1;
        pins.ready = 1'b0;
        unique case (state)
            ST_RUN: begin
                pins.own   = 1'b0;
                pins.ready = 1'b1;
            end
            ST_ENTER: pins.cke = 1'b0;
            ST_DOWN: begin
                pins.cke = 1'b0;
                pins.cmd = down_cmd;
            end
            ST_EXIT: pins.cmd = CMD_NOP;
            default: ;
        endcase
    end
endmodule

// File: rtl/pdn_seq.sv
`timescale 1ns/1ps
module pdn_seq
    import pdn_pkg::*;
#(
    parameter int unsigned NBANK      = 4,
    parameter int unsigned CLK_PS     = 7500,
    parameter int unsigned REF_ROW_NS = 15625,
    parameter int unsigned MARGIN     = 16,
    parameter bit          DOWN_DESEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle_req,
    input  logic             access_busy,
    input  logic             wake_req,
    input  logic             new_access,
    input  logic [NBANK-1:0] bank_open,
    output logic             cke,
    output logic [3:0]       cmd,
    output logic             cmd_own,
    output logic             ready,
    output logic [1:0]       pd_mode,
    output logic             refresh_due
);
    localparam int unsigned REF_CYC = ns_to_cyc(REF_ROW_NS, CLK_PS);
    localparam int unsigned CNT_W   = $clog2(REF_CYC + 1);

    pdn_state_e state;
    pdn_mode_e  mode;
    pdn_pins_t  pins;
    logic       due, load, run, hit;

    pdn_budget #(.REF_CYC(REF_CYC), .MARGIN(MARGIN), .CNT_W(CNT_W)) u_budget (
        .clk(clk), .rst(rst), .load(load), .run(run), .hit(hit)
    );

    pdn_fsm u_fsm (
        .clk(clk), .rst(rst), .idle_req(idle_req), .access_busy(access_busy),
        .wake_req(wake_req), .new_access(new_access), .any_open(|bank_open),
        .budget_hit(hit), .state(state), .mode(mode), .due(due),
        .load(load), .run(run)
    );

    pdn_pins #(.DOWN_DESEL(DOWN_DESEL)) u_pins (.state(state), .pins(pins));

    assign cke         = pins.cke;
    assign cmd         = pins.cmd;
    assign cmd_own     = pins.own;
    assign ready       = pins.ready;
    assign pd_mode     = mode;
    assign refresh_due = due;
endmodule

// File: rtl/pdn_seq_chk.sv
`timescale 1ns/1ps
module pdn_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       idle_req,
    input logic       access_busy,
    input logic       wake_req,
    input logic       new_access,
    input logic       cke,
    input logic [3:0] cmd,
    input logic       cmd_own,
    input logic       ready,
    input logic [1:0] pd_mode,
    input logic       refresh_due
);
    AST_ENTRY_GUARDED: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> $past(idle_req && !access_busy && !wake_req && !new_access)); // R3
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        pd_mode != 2'd3); // R4
    AST_MODE_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (pd_mode != 2'd0) |-> (!ready && cmd_own)); // R9
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (pd_mode != 2'd0 && $past(pd_mode) != 2'd0) |-> $stable(pd_mode)); // R5
    AST_EXIT_NOP: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (cmd == 4'b0111 && !ready)); // R6
    AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (rst)
        (!cke && pd_mode != 2'd0 && (wake_req || new_access)) |=> cke); // R6
    AST_DUE_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
        refresh_due |-> (cke && !ready && pd_mode != 2'd0)); // R8
    AST_DOWN_DESEL: assert property (@(posedge clk) disable iff (rst)
        (!cke && pd_mode != 2'd0) |-> cmd[3]); // R7
endmodule

bind pdn_seq pdn_seq_chk u_chk (
    .clk(clk), .rst(rst), .idle_req(idle_req), .access_busy(access_busy),
    .wake_req(wake_req), .new_access(new_access), .cke(cke), .cmd(cmd),
    .cmd_own(cmd_own), .ready(ready), .pd_mode(pd_mode), .refresh_due(refresh_due)
);

// File: tb/pdn_seq_bench.sv
`timescale 1ns/1ps
module pdn_seq_bench;
    localparam int NB     = 4;
    localparam int CPS    = 5000;
    localparam int ROWNS  = 15625;
    localparam int MRG    = 16;
    localparam int REFC   = (ROWNS * 1000 + CPS - 1) / CPS;   // 3125
    localparam int LOWLEN = REFC - MRG + 1;                   // 3110

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          idle_req = 0, access_busy = 0, wake_req = 0, new_access = 0;
    logic [NB-1:0] bank_open = '0;
    logic          cke, cmd_own, ready, refresh_due;
    logic [3:0]    cmd;
    logic [1:0]    pd_mode;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pdn_seq #(.NBANK(NB), .CLK_PS(CPS), .REF_ROW_NS(ROWNS), .MARGIN(MRG),
              .DOWN_DESEL(1'b1)) u_pdn_seq (
        .clk(clk), .rst(rst), .idle_req(idle_req), .access_busy(access_busy),
        .wake_req(wake_req), .new_access(new_access), .bank_open(bank_open),
        .cke(cke), .cmd(cmd), .cmd_own(cmd_own), .ready(ready),
        .pd_mode(pd_mode), .refresh_due(refresh_due)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 usable, 1 entering, 2 down, 3 leaving
    int m_ph = 0, m_left = 0, m_kind = 0, m_mode = 0, m_due = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_left = 0; m_mode = 0; m_due = 0;
        end else begin
            case (m_ph)
                0: if (idle_req && !access_busy && !wake_req && !new_access) begin
                       m_ph = 1; m_left = REFC; m_kind = (bank_open != 0) ? 2 : 1;
                   end
                1: begin m_ph = 2; m_mode = m_kind; m_left--; end
                2: begin
                       if (m_left == MRG) begin m_ph = 3; m_due = 1; end
                       else if (wake_req || new_access) m_ph = 3;
                       if (m_left > 0) m_left--;
                   end
                default: begin m_ph = 0; m_mode = 0; m_due = 0; end
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2", "model cke", int'(cke), (m_ph == 1 || m_ph == 2) ? 0 : 1);
            chk("R7", "model cmd", int'(cmd), (m_ph == 2) ? 15 : 7);
            chk("R7", "model cmd_own", int'(cmd_own), (m_ph != 0) ? 1 : 0);
            chk("R9", "model ready", int'(ready), (m_ph == 0) ? 1 : 0);
            chk("R4", "model pd_mode", int'(pd_mode), m_mode);
            chk("R8", "model refresh_due", int'(refresh_due), m_due);
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        cyc(3);
        chk("R1", "cke in reset", int'(cke), 1);
        chk("R1", "pd_mode in reset", int'(pd_mode), 0);
        rst = 1'b0;
        cyc(1);
        chk("R1", "ready after reset", int'(ready), 1);
        chk("R1", "cmd_own after reset", int'(cmd_own), 0);
        chk("R1", "refresh_due after reset", int'(refresh_due), 0);

        // precharge power-down, wake exit
        idle_req = 1;
        cyc(1);
        chk("R2", "cke entry cycle", int'(cke), 0);
        chk("R2", "mode in entry cycle", int'(pd_mode), 0);
        chk("R2", "cmd in entry cycle", int'(cmd), 7);
        cyc(1);
        chk("R4", "precharge mode", int'(pd_mode), 1);
        chk("R7", "deselect while down", int'(cmd), 15);
        idle_req = 0;
        cyc(5);
        chk("R10", "idle drop ignored", int'(cke), 0);
        bank_open = 4'b0010;
        cyc(3);
        chk("R5", "mode latched", int'(pd_mode), 1);
        chk("R5", "cke held low", int'(cke), 0);
        wake_req = 1;
        cyc(1);
        wake_req = 0;
        chk("R6", "cke on wake", int'(cke), 1);
        chk("R6", "NOP on exit", int'(cmd), 7);
        chk("R6", "ready in exit", int'(ready), 0);
        chk("R6", "no due on wake", int'(refresh_due), 0);
        cyc(1);
        chk("R6", "ready after exit", int'(ready), 1);
        chk("R6", "mode cleared", int'(pd_mode), 0);

        // guarded entry
        idle_req = 1; access_busy = 1;
        cyc(4);
        chk("R3", "busy blocks entry", int'(cke), 1);
        access_busy = 0; new_access = 1;
        cyc(3);
        chk("R3", "pending access blocks", int'(cke), 1);
        new_access = 0; wake_req = 1;
        cyc(2);
        chk("R3", "wake blocks entry", int'(ready), 1);
        wake_req = 0;

        // active power-down, new access exit
        cyc(2);
        chk("R4", "active mode", int'(pd_mode), 2);
        idle_req = 0;
        new_access = 1;
        cyc(1);
        new_access = 0;
        chk("R6", "cke on new access", int'(cke), 1);
        cyc(1);
        chk("R6", "ready after access exit", int'(ready), 1);

        // budget-forced exit
        bank_open = '0;
        idle_req = 1;
        cyc(1);
        idle_req = 0;
        begin
            int lowc = 0;
            while (cke == 1'b0 && lowc < 10000) begin
                lowc++;
                cyc(1);
            end
            chk("R8", "cycles with cke low", lowc, LOWLEN);
            chk("R8", "refresh_due on forced exit", int'(refresh_due), 1);
            chk("R8", "cmd on forced exit", int'(cmd), 7);
        end
        cyc(1);
        chk("R8", "refresh_due clears", int'(refresh_due), 0);
        chk("R9", "ready after forced exit", int'(ready), 1);

        cyc(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule